// File: doc/BRIEF.md
# Context Stack with Selective Restore

This block keeps saved processor contexts for subroutine calls and interrupt entry. Each entry is 53 bits wide and holds the program counter together with the table pointer, data bank, working-register page, ROM page, RAM page, accumulator and carry. The entries are used last in, first out. A push writes the whole context in one cycle. A pop reads the most recent entry back.

A return always brings back the program counter. A 7-bit mask chooses which of the other field groups come back as well. The block presents the restored entry together with one load strobe per field group. The register file loads only the groups whose strobe is high, so every group that is not selected keeps its live value.

Storage is a circular buffer addressed by a wrapping pointer, so a push is never refused. A seventeenth outstanding push overwrites the oldest entry. A pop on an empty stack wraps backwards and returns whatever is stored in that slot.

Top module: `ctx_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, every stored entry is cleared to zero and the pointer returns to slot 0. After reset, `load_o` and `rest_ctx_o` read zero.
- R2: A pop returns the most recent entry that has been pushed and not yet popped (last in, first out).
- R3: Every pop asserts `load_o[0]` (program counter). The program counter field `rest_ctx_o[52:38]` carries the saved value whatever the mask is; a mask of zero restores only the program counter.
- R4: The entry layout, MSB first, is: PC [52:38], table pointer [37:22], bank low [21:18], bank high [17:16], working-register page [15:12], ROM page [11:8], RAM page [7:5], accumulator [4:1], carry [0]. `load_o[k+1]` equals `pop_mask_i[k]` of the pop. Mask bit 0 selects the table pointer, bit 1 both bank fields, bit 2 the working-register page, bit 3 the ROM page, bit 4 the RAM page, bit 5 the accumulator and bit 6 the carry.
- R5: On a pop, every field whose group is not selected by the mask reads zero on `rest_ctx_o`, and its strobe is low.
- R6: `rest_ctx_o` and `load_o` change one clock after the pop is sampled. The strobes are high for exactly that one cycle. In a cycle with no pop, `load_o` is zero and `rest_ctx_o` holds its previous value.
- R7: Push never stalls. After 17 pushes with no pops, the first push is lost: the next 16 pops return pushes 17 down to 2, and a further pop returns push 17 again.
- R8: A pop when no entry is outstanding wraps the pointer back by one and returns the slot found there. After 16 pushes and 16 pops, one more pop returns the 16th push.
- R9: A push and a pop in the same cycle return the current top entry and replace it with the pushed context. The depth is unchanged, so the next pop returns the pushed context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Save `push_ctx_i` on top of the stack |
| push_ctx_i | input | 53 | Context to be saved (layout in R4) |
| pop_i | input | 1 | Restore the top entry |
| pop_mask_i | input | 7 | Field groups to restore besides the PC |
| rest_ctx_o | output | 53 | Restored context; unselected fields read zero |
| load_o | output | 8 | Per-group load strobes: bit 0 PC, bits 7:1 the mask groups |

## Verification
The assertions check on every cycle that:
- strobes appear only in the cycle after a pop;
- the PC strobe accompanies every pop;
- the strobe vector matches the mask;
- the carry and accumulator fields read zero when they are not selected;
- the pointer moves by exactly one step per push or pop and stays put for a combined push and pop.

Only the bench scenarios can show that the data returned is right. This covers the last-in, first-out order, the loss of the oldest entry on overflow, the wrap-around read on an empty stack and the replace-on-top behaviour of a combined push and pop. The bench compares these against its own model of the circular buffer, under random and directed sequences.

// File: rtl/ctx_stack_pkg.sv
// Package: context stack field widths, field positions and the mask-to-field expansion.
// Assumes the field order defined here is the one the register file packs onto the bus.
package ctx_stack_pkg;
    localparam int PC_W    = 15;
    localparam int TAB_W   = 16;
    localparam int BLO_W   = 4;
    localparam int BHI_W   = 2;
    localparam int WRP_W   = 4;
    localparam int ROM_W   = 4;
    localparam int PAGE_W  = 3;
    localparam int ACC_W   = 4;
    localparam int CF_W    = 1;
    localparam int CTX_W   = PC_W + TAB_W + BLO_W + BHI_W + WRP_W + ROM_W + PAGE_W + ACC_W + CF_W;
    localparam int MASK_W  = 7;
    localparam int LOAD_W  = MASK_W + 1;

    localparam int CF_LSB  = 0;
    localparam int ACC_LSB = CF_LSB + CF_W;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [TAB_W-1:0]  tab;
        logic [BLO_W-1:0]  bank_lo;
        logic [BHI_W-1:0]  bank_hi;
        logic [WRP_W-1:0]  wr_page;
        logic [ROM_W-1:0]  rom_page;
        logic [PAGE_W-1:0] ram_page;
        logic [ACC_W-1:0]  acc;
        logic [CF_W-1:0]   cf;
    } ctx_t;

    // Expand a restore mask into a per-bit keep vector; the PC is always kept.
    function automatic ctx_t keep_vector(input logic [MASK_W-1:0] m);
        ctx_t k;
        k.pc       = '1;
        k.tab      = {TAB_W{m[0]}};
        k.bank_lo  = {BLO_W{m[1]}};
        k.bank_hi  = {BHI_W{m[1]}};
        k.wr_page  = {WRP_W{m[2]}};
        k.rom_page = {ROM_W{m[3]}};
        k.ram_page = {PAGE_W{m[4]}};
        k.acc      = {ACC_W{m[5]}};
        k.cf       = {CF_W{m[6]}};
        return k;
    endfunction
endpackage

// File: rtl/ctx_stack_ptr.sv
// Module: wrapping stack pointer. Holds the index of the next free slot.
// Assumes DEPTH is a power of two, so pointer arithmetic wraps at the buffer size.
// Push writes at the pointer; pop reads one below it; push+pop rewrites the top in place.
module ctx_stack_ptr #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic [PTR_W-1:0] level
);
    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] top_idx;

    // Top-of-stack slot, wrapping below slot 0.
    always_comb top_idx = sp_q - PTR_W'(1);

    // Write slot: the top when replacing, the free slot otherwise.
    always_comb begin
        rd_idx = top_idx;
        wr_idx = pop ? top_idx : sp_q;
        level  = sp_q;
    end

    // Pointer update: up on push, down on pop, unchanged on both or neither.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   sp_q <= sp_q + PTR_W'(1);
                2'b01:   sp_q <= top_idx;
                default: sp_q <= sp_q;
            endcase
        end
    end
endmodule

// File: rtl/ctx_stack_mem.sv
// Module: register array holding the saved contexts, one register per slot.
// Assumes a single write port and a combinational read; contents clear on reset.
module ctx_stack_mem #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 53,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Slot storage: load when selected by a push.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(s))) begin
                slot_q[s] <= wr_data;
            end
        end
    end

    // Read port: the slot selected by the pointer.
    always_comb rd_data = slot_q[rd_idx];
endmodule

// File: rtl/ctx_stack_restore.sv
// Module: restore stage. Registers the popped entry with unselected groups zeroed,
// and raises one load strobe per selected group for one cycle.
// Assumes the register file loads a group only while its strobe is high.
module ctx_stack_restore
    import ctx_stack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic [MASK_W-1:0] mask,
    input  logic [CTX_W-1:0]  rd_data,
    output logic [CTX_W-1:0]  rest_ctx,
    output logic [LOAD_W-1:0] load
);
    logic [CTX_W-1:0] keep;

    // Bit-level keep vector from the restore mask.
    always_comb keep = keep_vector(mask);

    // Output data: captured on a pop, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rest_ctx <= '0;
        end else if (pop) begin
            rest_ctx <= rd_data & keep;
        end
    end

    // Load strobes: PC plus the masked groups, for one cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load <= '0;
        end else begin
            load <= pop ? {mask, 1'b1} : '0;
        end
    end
endmodule

// File: rtl/ctx_stack.sv
// Module: context stack top. Circular LIFO of full processor contexts with a
// masked restore. Never refuses a push; an overflow overwrites the oldest entry.
// Assumes DEPTH is a power of two.
module ctx_stack
    import ctx_stack_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [CTX_W-1:0]  push_ctx_i,
    input  logic              pop_i,
    input  logic [MASK_W-1:0] pop_mask_i,
    output logic [CTX_W-1:0]  rest_ctx_o,
    output logic [LOAD_W-1:0] load_o
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic [PTR_W-1:0] sp_lvl;
    logic [CTX_W-1:0] rd_data;

    ctx_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push_i),
        .pop    (pop_i),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx),
        .level  (sp_lvl)
    );

    ctx_stack_mem #(.DEPTH(DEPTH), .WIDTH(CTX_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_i),
        .wr_idx  (wr_idx),
        .wr_data (push_ctx_i),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    ctx_stack_restore u_rest (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (pop_i),
        .mask     (pop_mask_i),
        .rd_data  (rd_data),
        .rest_ctx (rest_ctx_o),
        .load     (load_o)
    );
endmodule

// File: rtl/ctx_stack_chk.sv
// Module: assertion checker for the context stack, bound into the top module.
// Assumes the pointer level is the index of the next free slot.
module ctx_stack_chk
    import ctx_stack_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic [MASK_W-1:0] pop_mask_i,
    input logic [CTX_W-1:0]  rest_ctx_o,
    input logic [LOAD_W-1:0] load_o,
    input logic [PTR_W-1:0]  sp_q
);
    AST_STROBE_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n) (|load_o) |-> $past(pop_i)); // R6
    AST_PC_ON_POP:        assert property (@(posedge clk) disable iff (!rst_n) pop_i |=> load_o[0]); // R3
    AST_MASK_TO_STROBE:   assert property (@(posedge clk) disable iff (!rst_n) pop_i |=> (load_o[LOAD_W-1:1] == $past(pop_mask_i))); // R4
    AST_CF_ZERO_UNSEL:    assert property (@(posedge clk) disable iff (!rst_n) (load_o[0] && !load_o[7]) |-> (rest_ctx_o[CF_LSB] == 1'b0)); // R5
    AST_ACC_ZERO_UNSEL:   assert property (@(posedge clk) disable iff (!rst_n) (load_o[0] && !load_o[6]) |-> (rest_ctx_o[ACC_LSB +: ACC_W] == '0)); // R5
    AST_PUSH_STEP:        assert property (@(posedge clk) disable iff (!rst_n) (push_i && !pop_i) |=> (sp_q == PTR_W'($past(sp_q) + 1))); // R7
    AST_POP_STEP:         assert property (@(posedge clk) disable iff (!rst_n) (pop_i && !push_i) |=> (sp_q == PTR_W'($past(sp_q) - 1))); // R8
    AST_SWAP_HOLD:        assert property (@(posedge clk) disable iff (!rst_n) (pop_i && push_i) |=> $stable(sp_q)); // R9
endmodule

bind ctx_stack ctx_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .pop_mask_i (pop_mask_i),
    .rest_ctx_o (rest_ctx_o),
    .load_o     (load_o),
    .sp_q       (sp_lvl)
);

// File: tb/ctx_stack_tb_top.sv
// Bench: directed corner cases plus seeded random push/pop traffic checked
// against a bench-side circular-buffer model built from the requirements.
module ctx_stack_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic [52:0] push_ctx_i = '0;
    logic        pop_i = 1'b0;
    logic [6:0]  pop_mask_i = '0;
    logic [52:0] rest_ctx_o;
    logic [7:0]  load_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [52:0] m_mem [16];
    int          m_sp = 0;

    always #2.5 clk = ~clk;

    ctx_stack dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_i),
        .push_ctx_i (push_ctx_i),
        .pop_i      (pop_i),
        .pop_mask_i (pop_mask_i),
        .rest_ctx_o (rest_ctx_o),
        .load_o     (load_o)
    );

    // Bit-level keep vector from the R4 layout.
    function automatic logic [52:0] keep_of(input logic [6:0] m);
        logic [52:0] k = '0;
        k[52:38] = '1;
        if (m[0]) k[37:22] = '1;
        if (m[1]) k[21:16] = '1;
        if (m[2]) k[15:12] = '1;
        if (m[3]) k[11:8]  = '1;
        if (m[4]) k[7:5]   = '1;
        if (m[5]) k[4:1]   = '1;
        if (m[6]) k[0]     = 1'b1;
        return k;
    endfunction

    function automatic logic [52:0] rnd_ctx();
        logic [63:0] t = {$urandom(), $urandom()};
        return t[52:0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus, driven at a falling edge and checked at the next one.
    task automatic step(input bit psh, input bit pp, input logic [6:0] msk,
                        input logic [52:0] dat, input string tag);
        logic [52:0] exp_d;
        logic [52:0] prev;
        int idx;
        prev = rest_ctx_o;
        exp_d = prev;
        push_i = psh; pop_i = pp; pop_mask_i = msk; push_ctx_i = dat;
        if (pp) begin
            idx = (m_sp + 15) % 16;
            exp_d = m_mem[idx] & keep_of(msk);
            if (psh) m_mem[idx] = dat;
            else m_sp = idx;
        end else if (psh) begin
            m_mem[m_sp] = dat;
            m_sp = (m_sp + 1) % 16;
        end
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
        if (pp) begin
            check(load_o == {msk, 1'b1}, "R4 strobes", 64'(load_o), 64'({msk, 1'b1}));
            check(rest_ctx_o == exp_d, tag, 64'(rest_ctx_o), 64'(exp_d));
        end else begin
            check(load_o == 8'h00, "R6 idle strobes", 64'(load_o), 64'h0);
            check(rest_ctx_o == exp_d, "R6 hold", 64'(rest_ctx_o), 64'(exp_d));
        end
    endtask

    initial begin
        logic [52:0] a;
        logic [52:0] b;
        void'($urandom(32'h0c5_7ac4));
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(load_o == 8'h00, "R1 strobes", 64'(load_o), 64'h0);
        check(rest_ctx_o == '0, "R1 data", 64'(rest_ctx_o), 64'h0);

        // R3: mask zero restores only the PC
        a = rnd_ctx();
        step(1, 0, 7'h00, a, "R2");
        step(0, 1, 7'h00, '0, "R3 pc only");
        // R4/R5: each single group
        for (int k = 0; k < 7; k++) begin
            a = rnd_ctx();
            step(1, 0, 7'h00, a, "R2");
            step(0, 1, 7'(1 << k), '0, "R4 single group R5");
        end
        // R2: full mask, nested order
        a = rnd_ctx(); b = rnd_ctx();
        step(1, 0, 7'h00, a, "R2");
        step(1, 0, 7'h00, b, "R2");
        step(0, 1, 7'h7f, '0, "R2 top");
        step(0, 0, 7'h00, '0, "R6");
        step(0, 1, 7'h7f, '0, "R2 next");
        // R9: combined push and pop
        a = rnd_ctx(); b = rnd_ctx();
        step(1, 0, 7'h00, a, "R2");
        step(1, 1, 7'h7f, b, "R9 swap returns top");
        step(0, 1, 7'h7f, '0, "R9 replaced top");
        // R7: 17 pushes, 17 pops
        for (int i = 0; i < 17; i++) step(1, 0, 7'h00, rnd_ctx(), "R7");
        for (int i = 0; i < 17; i++) step(0, 1, 7'h7f, '0, "R7 overflow order");
        // R8: fill, drain, then one extra pop wraps
        while (m_sp != 0) step(1, 0, 7'h00, rnd_ctx(), "R8");
        for (int i = 0; i < 16; i++) step(1, 0, 7'h00, rnd_ctx(), "R8");
        for (int i = 0; i < 16; i++) step(0, 1, 7'h7f, '0, "R8 drain");
        step(0, 1, 7'h7f, '0, "R8 empty wrap");
        // Random traffic
        for (int i = 0; i < 600; i++) begin
            int r = $urandom % 8;
            logic [6:0] m = 7'($urandom);
            if (r < 3) step(1, 0, m, rnd_ctx(), "R2");
            else if (r < 6) step(0, 1, m, '0, "R2 random pop R5");
            else if (r == 6) step(1, 1, m, rnd_ctx(), "R9 random");
            else step(0, 0, m, '0, "R6");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule